// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the instruction address for a small core whose instructions are 12 bits wide. On every instruction cycle it either steps to the next word or loads a new address. A load happens on a jump, a subroutine call, a return, or a write to the low address byte from the data bus. The address space is split into 512-word pages. The page number sits in the bits above the jump field and always comes from a page-select input, which is driven by a status register outside this block.

Jumps take the full 9-bit literal, so a jump can reach any word of the selected page. Calls and low-byte writes supply only 8 bits and force bit 8 to zero. This confines subroutine entry points and computed jumps to the lower half of a page.

After reset the address points at the very last word of the address space. The word there holds a calibration constant load. Stepping once from it wraps the address to zero, where user code begins.

The unit also gives out the incremented address, which the call-stack logic pushes as the return address. The current address is visible on the output, so the low byte can be read as a data register.

Top module: `pcu_top`

## Requirements
- R1: While `rst` is high at a rising edge, the address becomes all ones (1023 at the default width), whatever the enable, operation code or other inputs.
- R2: Operation code 0 (step) with the enable high sets the address to the old address plus one, modulo 2^ADDR_W, so 1023 wraps to 0.
- R3: Operation code 1 (jump) with the enable high loads bits 8:0 from `lit_i[8:0]` and bit 9 from `page_i`.
- R4: Operation code 2 (call) with the enable high loads bits 7:0 from `lit_i[7:0]`, clears bit 8 and loads bit 9 from `page_i`. `lit_i[8]` has no effect.
- R5: Operation code 3 (low-byte write) with the enable high loads bits 7:0 from `dbus_i`, clears bit 8 and loads bit 9 from `page_i`.
- R6: Operation code 4 (return) with the enable high loads the whole address from `tos_i`.
- R7: With `cyc_en_i` low and reset low, the address holds its value for every operation code.
- R8: Operation codes 5, 6 and 7 behave exactly like code 0.
- R9: `pc_plus1_o` always equals `pc_o` plus one, modulo 2^ADDR_W, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en_i | input | 1 | Instruction-cycle enable; the address changes only while this is high |
| op_i | input | 3 | Operation code: 0 step, 1 jump, 2 call, 3 low-byte write, 4 return |
| lit_i | input | LIT_W (9) | Literal field of the instruction |
| dbus_i | input | BYTE_W (8) | Data-bus byte for a low-byte write |
| page_i | input | ADDR_W-LIT_W (1) | Page-select bits from the status register |
| tos_i | input | ADDR_W (10) | Top-of-stack return address |
| pc_o | output | ADDR_W (10) | Current instruction address; bits 7:0 are the readable low byte |
| pc_plus1_o | output | ADDR_W (10) | Current address plus one, the value to push on a call |

## Verification
The assertions assume that `op_i`, `lit_i`, `dbus_i`, `page_i` and `tos_i` hold known, non-X values at every rising edge where `cyc_en_i` is high. They also assume that reset is applied synchronously before the first enabled cycle. The stimulus drives every input on the falling edge from one task and keeps reset high for two full cycles at the start. So every sampled value is settled and defined. Reset is raised again only together with a load request, to exercise its priority.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JUMP = 3'd1,
    OP_CALL = 3'd2,
    OP_LWR  = 3'd3,
    OP_RET  = 3'd4
  } pc_op_e;

endpackage

// File: rtl/pcu_incr.sv
module pcu_incr #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] a_i,
  output logic [ADDR_W-1:0] y_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb y_o = a_i + ONE;

  always_comb begin
    p_incr_wrap_r9: assert (a_i == '1 ? y_o == '0 : y_o > a_i)
      else $error("incrementer result inconsistent");
  end
endmodule

// File: rtl/pcu_target.sv
module pcu_target
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LIT_W  = 9,
  parameter int BYTE_W = 8
) (
  input  logic [2:0]              op_i,
  input  logic [LIT_W-1:0]        lit_i,
  input  logic [BYTE_W-1:0]       dbus_i,
  input  logic [ADDR_W-LIT_W-1:0] page_i,
  input  logic [ADDR_W-1:0]       tos_i,
  input  logic [ADDR_W-1:0]       inc_i,
  output logic [ADDR_W-1:0]       nxt_o
);
  localparam int PAGE_W = ADDR_W - LIT_W;
  localparam int GAP_W  = LIT_W - BYTE_W;

  logic [ADDR_W-1:0] jump_a, call_a, lwr_a;

  // Short loads: the bits between the byte and the page are cleared.
  generate
    if (GAP_W > 0) begin : g_gap
      always_comb begin
        call_a = {page_i, {GAP_W{1'b0}}, lit_i[BYTE_W-1:0]};
        lwr_a  = {page_i, {GAP_W{1'b0}}, dbus_i};
      end
    end else begin : g_nogap
      always_comb begin
        call_a = {page_i, lit_i[BYTE_W-1:0]};
        lwr_a  = {page_i, dbus_i};
      end
    end
  endgenerate

  always_comb jump_a = {page_i, lit_i};

  always_comb begin
    case (pc_op_e'(op_i))
      OP_JUMP: nxt_o = jump_a;
      OP_CALL: nxt_o = call_a;
      OP_LWR:  nxt_o = lwr_a;
      OP_RET:  nxt_o = tos_i;
      default: nxt_o = inc_i;
    endcase
  end

  always_comb begin
    p_page_src_r3: assert (op_i == 3'd0 || op_i > 3'd4 || op_i == 3'd4 ||
                           nxt_o[ADDR_W-1 -: PAGE_W] == page_i)
      else $error("page bits not taken from page select");
  end
endmodule

// File: rtl/pcu_reg.sv
module pcu_reg #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);
  localparam logic [ADDR_W-1:0] RESET_VAL = '1;

  logic rst_d;

  always_ff @(posedge clk) begin
    if (rst)       q_o <= RESET_VAL;
    else if (en_i) q_o <= d_i;
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      p_reset_vec_r1: assert (q_o == RESET_VAL)
        else $error("address not at reset vector after reset");
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(q_o))
    else $error("address moved while the cycle enable was low");
endmodule

// File: rtl/pcu_top.sv
module pcu_top #(
  parameter int ADDR_W = 10,
  parameter int LIT_W  = 9,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_en_i,
  input  logic [2:0]              op_i,
  input  logic [LIT_W-1:0]        lit_i,
  input  logic [BYTE_W-1:0]       dbus_i,
  input  logic [ADDR_W-LIT_W-1:0] page_i,
  input  logic [ADDR_W-1:0]       tos_i,
  output logic [ADDR_W-1:0]       pc_o,
  output logic [ADDR_W-1:0]       pc_plus1_o
);
  localparam int PAGE_W = ADDR_W - LIT_W;

  logic [ADDR_W-1:0] pc_q, pc_inc, pc_nxt;

  pcu_incr #(.ADDR_W(ADDR_W)) i_incr (
    .a_i (pc_q),
    .y_o (pc_inc)
  );

  pcu_target #(.ADDR_W(ADDR_W), .LIT_W(LIT_W), .BYTE_W(BYTE_W)) i_target (
    .op_i   (op_i),
    .lit_i  (lit_i),
    .dbus_i (dbus_i),
    .page_i (page_i),
    .tos_i  (tos_i),
    .inc_i  (pc_inc),
    .nxt_o  (pc_nxt)
  );

  pcu_reg #(.ADDR_W(ADDR_W)) i_reg (
    .clk  (clk),
    .rst  (rst),
    .en_i (cyc_en_i),
    .d_i  (pc_nxt),
    .q_o  (pc_q)
  );

  assign pc_o       = pc_q;
  assign pc_plus1_o = pc_inc;

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    cyc_en_i && (op_i == 3'd0 || op_i > 3'd4) |=>
      pc_o == ADDR_W'($past(pc_o) + 1'b1))
    else $error("step or unused code did not advance by one");

  p_jump_r3: assert property (@(posedge clk) disable iff (rst)
    cyc_en_i && op_i == 3'd1 |=>
      pc_o[LIT_W-1:0] == $past(lit_i) && pc_o[ADDR_W-1 -: PAGE_W] == $past(page_i))
    else $error("jump target wrong");

  p_call_r4: assert property (@(posedge clk) disable iff (rst)
    cyc_en_i && op_i == 3'd2 |=>
      pc_o[BYTE_W-1:0] == $past(lit_i[BYTE_W-1:0]) && pc_o[LIT_W-1:BYTE_W] == '0)
    else $error("call target wrong");

  p_lwr_r5: assert property (@(posedge clk) disable iff (rst)
    cyc_en_i && op_i == 3'd3 |=>
      pc_o[BYTE_W-1:0] == $past(dbus_i) && pc_o[LIT_W-1:BYTE_W] == '0)
    else $error("low-byte write target wrong");

  p_ret_r6: assert property (@(posedge clk) disable iff (rst)
    cyc_en_i && op_i == 3'd4 |=> pc_o == $past(tos_i))
    else $error("return did not load top of stack");
endmodule

// File: tb/test_pcu_top.sv
module test_pcu_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [2:0] op = 3'd0;
  logic [8:0] lit = '0;
  logic [7:0] dbus = '0;
  logic       page = 1'b0;
  logic [9:0] tos = '0;
  logic [9:0] pc, pc1;

  int checks = 0;
  int fails = 0;
  logic [9:0] mdl;

  always #5 clk = ~clk;

  pcu_top i_pcu_top (
    .clk(clk), .rst(rst), .cyc_en_i(en), .op_i(op), .lit_i(lit),
    .dbus_i(dbus), .page_i(page), .tos_i(tos), .pc_o(pc), .pc_plus1_o(pc1)
  );

  function automatic logic [9:0] model(input logic [9:0] cur, input logic [2:0] o,
    input logic [8:0] l, input logic [7:0] d, input logic p, input logic [9:0] t,
    input logic e);
    if (!e) return cur;
    case (o)
      3'd1: return p * 512 + l;
      3'd2: return p * 512 + (l % 256);
      3'd3: return p * 512 + d;
      3'd4: return t;
      default: return (cur + 1) % 1024;
    endcase
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at negedge, let one rising edge pass, sample at the next negedge.
  task automatic cyc(input string req, input logic [2:0] o, input logic [8:0] l,
    input logic [7:0] d, input logic p, input logic [9:0] t, input logic e);
    op = o; lit = l; dbus = d; page = p; tos = t; en = e;
    @(posedge clk);
    @(negedge clk);
    mdl = model(mdl, o, l, d, p, t, e);
    check(req, pc, mdl);
    check("R9", pc1, (mdl + 1) % 1024);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset with a pending jump.
    rst = 1'b1; en = 1'b1; op = 3'd1; lit = 9'h055; page = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", pc, 10'd1023);
    check("R9", pc1, 10'd0);
    rst = 1'b0;
    mdl = 10'd1023;

    // R2: full sequential sweep from the reset vector through the wrap.
    for (int i = 0; i < 1025; i++) cyc("R2", 3'd0, 9'h1AB, 8'h3C, 1'b1, 10'h2F0, 1'b1);

    // R3: every literal on both pages.
    for (int p = 0; p < 2; p++)
      for (int l = 0; l < 512; l++) cyc("R3", 3'd1, 9'(l), 8'hFF, 1'(p), 10'h155, 1'b1);

    // R4: every byte with both values of literal bit 8 on both pages.
    for (int p = 0; p < 2; p++)
      for (int l = 0; l < 512; l++) cyc("R4", 3'd2, 9'(l), 8'h00, 1'(p), 10'h3FF, 1'b1);

    // R5: every data byte on both pages, literal at all ones.
    for (int p = 0; p < 2; p++)
      for (int d = 0; d < 256; d++) cyc("R5", 3'd3, 9'h1FF, 8'(d), 1'(p), 10'h000, 1'b1);

    // R6: every stack value.
    for (int t = 0; t < 1024; t++) cyc("R6", 3'd4, 9'h0F0, 8'hA5, 1'b0, 10'(t), 1'b1);

    // R7: enable low holds under every code, after moving to a known place.
    cyc("R3", 3'd1, 9'h1C3, 8'h00, 1'b1, 10'h000, 1'b1);
    for (int o = 0; o < 8; o++) cyc("R7", 3'(o), 9'h011, 8'h22, 1'b0, 10'h033, 1'b0);

    // R8: unused codes step, including across the wrap.
    for (int o = 5; o < 8; o++) begin
      cyc("R6", 3'd4, 9'h000, 8'h00, 1'b0, 10'h3FE, 1'b1);
      cyc("R8", 3'(o), 9'h1FF, 8'hFF, 1'b1, 10'h000, 1'b1);
      cyc("R8", 3'(o), 9'h1FF, 8'hFF, 1'b1, 10'h000, 1'b1);
    end

    // R1: reset wins over a return request.
    rst = 1'b1; op = 3'd4; tos = 10'h012; en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", pc, 10'd1023);
    rst = 1'b0;
    mdl = 10'd1023;
    cyc("R2", 3'd0, 9'h000, 8'h00, 1'b0, 10'h000, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule